// File: doc/BRIEF.md
# Missing Clock Detector with Limp Switchover

This block decides whether a slow reference oscillator is still running by racing two counters that sit in different clock domains. A narrow counter runs on the reference clock itself. A wide counter runs on the fast clock that comes out of the on-chip PLL. Each time the narrow counter wraps, it sends an event across to the fast domain, and that event zeroes the wide counter. While the reference keeps ticking, the wide counter is reset long before it can reach its top value. When the reference stops, the PLL keeps running at its fallback rate, nothing clears the wide counter, and it eventually wraps. That wrap is the loss indication.

On detection the block raises a sticky loss flag and a single-cycle non-maskable interrupt request. When the limp-enable input is high, it also moves the processor clock select over to the fallback clock, and the select stays there until reset. The wide counter only advances while the PLL is running. The time to detect a loss is not fixed. It depends on the fast clock rate and on how far the wide counter had already advanced when the reference went quiet. The outputs and the clear strobe all belong to the fast clock domain. The reset is synchronous and is sampled in both domains.

Top module: `missing_clk_monitor`

## Requirements
- R1: While `rst` is high, and in the first fast-clock cycle after it falls, `miss_flag`, `nmi_req` and `clk_sel` are all 0 (0 selects the reference clock path, 1 selects the limp clock).
- R2: A REF_W-bit counter (default 7) advances on every rising edge of `ref_clk`. On each wrap from all-ones to zero it flips a toggle. The toggle passes through a two-flop synchronizer and edge detector into the `vco_clk` domain, and the resulting pulse zeroes the fast counter.
- R3: The FAST_W-bit fast counter (default 13) advances on each rising edge of `vco_clk` while `pll_off` is 0. It holds its value while `pll_off` is 1, although a clear pulse still zeroes it.
- R4: While `ref_clk` runs with a period shorter than 2^(FAST_W-REF_W) `vco_clk` periods, `miss_flag` never sets.
- R5: When the fast counter advances from all-ones, `miss_flag` is 1 from the next `vco_clk` edge on. After the last `ref_clk` edge this happens within 2^FAST_W + 3 counting `vco_clk` cycles.
- R6: `miss_flag` stays set until `stat_clr` is sampled high. If a wrap and `stat_clr` occur in the same cycle, the set wins.
- R7: `nmi_req` is high for exactly one `vco_clk` cycle, and that cycle is the first cycle in which `miss_flag` is 1. A wrap that occurs while `miss_flag` is already set issues no request.
- R8: `clk_sel` goes to 1 only on a wrap that occurs while `limp_en` is 1. It then stays 1 until reset. Raising `limp_en` later without a new wrap leaves it at 0.
- R9: If `stat_clr` clears `miss_flag` while the reference is still missing, the next wrap sets `miss_flag` again and issues a new `nmi_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Monitored reference oscillator clock |
| vco_clk | input | 1 | Fast PLL output clock; all outputs are in this domain |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| pll_off | input | 1 | High while the PLL is turned off; freezes the fast counter |
| limp_en | input | 1 | Allows the clock select to move to the limp clock on detection |
| stat_clr | input | 1 | Clear strobe for the loss flag, in the vco_clk domain |
| miss_flag | output | 1 | Sticky reference-loss flag |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| clk_sel | output | 1 | Processor clock select: 0 reference path, 1 limp clock |

## Verification
Some properties are checked on every fast-clock cycle: the interrupt request is always a single-cycle pulse that coincides with the flag's rise, the flag falls only after a clear strobe, the flag follows every wrap, a frozen PLL holds the counter, a crossing pulse zeroes it, and the clock select never returns to 0 or moves without an enabled wrap. Other behaviour depends on the relation between the two clock rates, so only the bench's scenarios can show it. That includes the fact that a healthy reference keeps the flag down over tens of thousands of cycles, the bounded detection latency after the reference stops, and the re-arming after a clear while the reference is still absent.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    localparam int REF_W_DEF  = 7;
    localparam int FAST_W_DEF = 13;
    localparam int SYNC_STAGES_DEF = 2;

    typedef enum logic {
        CLKSEL_REF  = 1'b0,
        CLKSEL_LIMP = 1'b1
    } clk_sel_e;

    typedef struct packed {
        logic     flag;
        logic     nmi;
        clk_sel_e sel;
    } alarm_state_t;

    // Loss flag: a wrap sets it, the clear strobe drops it, and a set takes priority.
    function automatic logic flag_next(input logic wrap, input logic clr, input logic cur);
        if (wrap)
            return 1'b1;
        else if (clr)
            return 1'b0;
        return cur;
    endfunction

    // Interrupt request: raised only on a wrap that finds the flag low.
    function automatic logic nmi_next(input logic wrap, input logic cur_flag);
        return wrap & ~cur_flag;
    endfunction

    // Clock select: moves to limp on an enabled wrap and stays there.
    function automatic clk_sel_e sel_next(input logic wrap, input logic en, input clk_sel_e cur);
        if (cur == CLKSEL_LIMP)
            return CLKSEL_LIMP;
        if (wrap && en)
            return CLKSEL_LIMP;
        return CLKSEL_REF;
    endfunction

endpackage

// File: rtl/mcd_ref_divider.sv
module mcd_ref_divider #(
    parameter int REF_W = mcd_pkg::REF_W_DEF
) (
    input  logic ref_clk,
    input  logic rst,
    output logic wrap_tgl
);

    localparam logic [REF_W-1:0] TOP = {REF_W{1'b1}};

    logic [REF_W-1:0] ref_cnt;
    logic             tgl_q;

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            ref_cnt <= '0;
            tgl_q   <= 1'b0;
        end else begin
            ref_cnt <= ref_cnt + 1'b1;
            if (ref_cnt == TOP)
                tgl_q <= ~tgl_q;
        end
    end

    assign wrap_tgl = tgl_q;

endmodule

// File: rtl/mcd_toggle_sync.sv
module mcd_toggle_sync #(
    parameter int STAGES = mcd_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic pulse
);

    // STAGES synchronizer flops, then one more flop used for edge detection
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)
                    chain[0] <= 1'b0;
                else
                    chain[0] <= tgl_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= 1'b0;
                else
                    chain[s] <= chain[s-1];
            end
        end
    end

    assign pulse = chain[DEPTH-1] ^ chain[DEPTH-2];

endmodule

// File: rtl/mcd_fast_counter.sv
module mcd_fast_counter #(
    parameter int FAST_W = mcd_pkg::FAST_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              run,
    output logic              wrap,
    output logic [FAST_W-1:0] cnt
);

    localparam logic [FAST_W-1:0] TOP = {FAST_W{1'b1}};

    logic [FAST_W-1:0] cnt_q;

    // A clear on the same cycle cancels the wrap.
    assign wrap = run & ~clr & (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/mcd_alarm.sv
module mcd_alarm
    import mcd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wrap,
    input  logic         stat_clr,
    input  logic         limp_en,
    output alarm_state_t state
);

    alarm_state_t st_q;
    alarm_state_t st_d;

    always_comb begin
        st_d.flag = flag_next(wrap, stat_clr, st_q.flag);
        st_d.nmi  = nmi_next(wrap, st_q.flag);
        st_d.sel  = sel_next(wrap, limp_en, st_q.sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.flag <= 1'b0;
            st_q.nmi  <= 1'b0;
            st_q.sel  <= CLKSEL_REF;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/missing_clk_monitor.sv
module missing_clk_monitor
    import mcd_pkg::*;
#(
    parameter int REF_W       = REF_W_DEF,
    parameter int FAST_W      = FAST_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic ref_clk,
    input  logic vco_clk,
    input  logic rst,
    input  logic pll_off,
    input  logic limp_en,
    input  logic stat_clr,
    output logic miss_flag,
    output logic nmi_req,
    output logic clk_sel
);

    logic              wrap_tgl;
    logic              clr_pulse;
    logic              fast_wrap;
    logic [FAST_W-1:0] fast_cnt;
    alarm_state_t      alarm_st;

    mcd_ref_divider #(.REF_W(REF_W)) i_ref_div (
        .ref_clk  (ref_clk),
        .rst      (rst),
        .wrap_tgl (wrap_tgl)
    );

    mcd_toggle_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (vco_clk),
        .rst    (rst),
        .tgl_in (wrap_tgl),
        .pulse  (clr_pulse)
    );

    mcd_fast_counter #(.FAST_W(FAST_W)) i_fast (
        .clk  (vco_clk),
        .rst  (rst),
        .clr  (clr_pulse),
        .run  (~pll_off),
        .wrap (fast_wrap),
        .cnt  (fast_cnt)
    );

    mcd_alarm i_alarm (
        .clk      (vco_clk),
        .rst      (rst),
        .wrap     (fast_wrap),
        .stat_clr (stat_clr),
        .limp_en  (limp_en),
        .state    (alarm_st)
    );

    assign miss_flag = alarm_st.flag;
    assign nmi_req   = alarm_st.nmi;
    assign clk_sel   = alarm_st.sel;

endmodule

// File: rtl/missing_clk_monitor_chk.sv
module missing_clk_monitor_chk #(
    parameter int FAST_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              pll_off,
    input logic              limp_en,
    input logic              stat_clr,
    input logic              clr,
    input logic              wrap,
    input logic [FAST_W-1:0] cnt,
    input logic              flag,
    input logic              nmi,
    input logic              sel
);

    // R7
    nmi_single_chk: assert property (@(posedge clk) disable iff (rst)
        nmi |=> !nmi);

    // R7
    nmi_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> nmi);

    // R7
    nmi_flag_chk: assert property (@(posedge clk) disable iff (rst)
        nmi |-> flag);

    // R6
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(stat_clr));

    // R5
    wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag);

    // R3
    pll_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pll_off && !clr) |=> (cnt == $past(cnt)));

    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R8
    limp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        sel |=> sel);

    // R8
    limp_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sel) |-> ($past(limp_en) && $past(wrap)));

endmodule

bind missing_clk_monitor missing_clk_monitor_chk #(.FAST_W(FAST_W)) i_chk (
    .clk      (vco_clk),
    .rst      (rst),
    .pll_off  (pll_off),
    .limp_en  (limp_en),
    .stat_clr (stat_clr),
    .clr      (clr_pulse),
    .wrap     (fast_wrap),
    .cnt      (fast_cnt),
    .flag     (miss_flag),
    .nmi      (nmi_req),
    .sel      (clk_sel)
);

// File: tb/test_missing_clk_monitor.sv
module test_missing_clk_monitor;

    localparam int VCO_PERIOD = 10;
    localparam int REF_HALF   = 20;
    localparam int FAST_SPAN  = 8192;
    localparam int WATCHDOG   = 190000;

    typedef struct packed {
        logic        ref_on;
        logic        pll_off;
        logic        limp_en;
        logic        clr;
        logic [15:0] cycles;
        logic        exp_flag;
        logic        exp_sel;
        logic [3:0]  exp_nmi;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'd20000, 1'b0, 1'b0, 4'd0}, // R4 healthy reference
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'd3000,  1'b0, 1'b0, 4'd0}, // R3 PLL off, ref on
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'd12000, 1'b0, 1'b0, 4'd0}, // R3 PLL off, ref lost
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'd9000,  1'b1, 1'b0, 4'd1}, // R5 R8 loss, limp off
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'd9000,  1'b1, 1'b1, 4'd1}, // R9 R8 re-arm, limp on
        '{1'b1, 1'b1, 1'b1, 1'b1, 16'd2000,  1'b0, 1'b1, 4'd0}, // R6 clear, select sticky
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'd4000,  1'b0, 1'b1, 4'd0}  // R8 R4 ref back
    };

    logic ref_clk  = 1'b0;
    logic vco_clk  = 1'b0;
    logic rst      = 1'b1;
    logic pll_off  = 1'b0;
    logic limp_en  = 1'b0;
    logic stat_clr = 1'b0;
    logic ref_run  = 1'b1;
    logic miss_flag;
    logic nmi_req;
    logic clk_sel;

    int n_checks = 0;
    int n_fail   = 0;
    int cycle_no = 0;
    int nmi_seen = 0;
    int flag_hi  = 0;

    missing_clk_monitor i_missing_clk_monitor (
        .ref_clk   (ref_clk),
        .vco_clk   (vco_clk),
        .rst       (rst),
        .pll_off   (pll_off),
        .limp_en   (limp_en),
        .stat_clr  (stat_clr),
        .miss_flag (miss_flag),
        .nmi_req   (nmi_req),
        .clk_sel   (clk_sel)
    );

    always #(VCO_PERIOD/2) vco_clk = ~vco_clk;

    initial begin
        #2;
        forever begin
            #(REF_HALF);
            if (ref_run)
                ref_clk = ~ref_clk;
        end
    end

    always @(posedge vco_clk) begin
        cycle_no++;
        if (cycle_no > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got cycle %0d expected below %0d", cycle_no, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, actual, expected);
        end
    endtask

    // Advances n fast cycles, counting request pulses and flag-high cycles at each negedge.
    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge vco_clk);
            if (nmi_req)   nmi_seen++;
            if (miss_flag) flag_hi++;
            stat_clr = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge vco_clk);
        rst = 1'b1;
        repeat (20) @(negedge vco_clk);
        check("R1 flag in reset", int'(miss_flag), 0);
        check("R1 nmi in reset", int'(nmi_req), 0);
        check("R1 sel in reset", int'(clk_sel), 0);
        rst = 1'b0;
        @(negedge vco_clk);
        check("R1 flag after reset", int'(miss_flag), 0);
        check("R1 sel after reset", int'(clk_sel), 0);
    endtask

    initial begin
        int lat;
        ref_run = 1'b1;
        do_reset();

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            ref_run  = VEC[v].ref_on;
            pll_off  = VEC[v].pll_off;
            limp_en  = VEC[v].limp_en;
            stat_clr = VEC[v].clr;
            nmi_seen = 0;
            run_cycles(int'(VEC[v].cycles));
            check($sformatf("R5/R6 flag vec %0d", v), int'(miss_flag), int'(VEC[v].exp_flag));
            check($sformatf("R8 sel vec %0d", v), int'(clk_sel), int'(VEC[v].exp_sel));
            check($sformatf("R7/R9 nmi count vec %0d", v), nmi_seen, int'(VEC[v].exp_nmi));
        end

        // R1: reset drops a set flag and a switched select
        ref_run = 1'b1;
        pll_off = 1'b0;
        limp_en = 1'b0;
        ref_run = 1'b0;
        run_cycles(FAST_SPAN + 100);
        limp_en = 1'b1;
        ref_run = 1'b1;
        do_reset();

        // R5: latency from reference stop to flag
        limp_en = 1'b1;
        run_cycles(1000);
        ref_run  = 1'b0;
        nmi_seen = 0;
        lat = 0;
        while (!miss_flag && lat < FAST_SPAN + 200) begin
            run_cycles(1);
            lat++;
        end
        check("R5 detected", int'(miss_flag), 1);
        check("R5 latency within bound", int'(lat <= FAST_SPAN + 4), 1);
        check("R5 latency not early", int'(lat >= FAST_SPAN - 600), 1);
        check("R7 one nmi on detect", nmi_seen, 1);
        check("R8 sel switched", int'(clk_sel), 1);

        // R6: clear held high while a wrap occurs; set wins for one cycle
        @(negedge vco_clk);
        stat_clr = 1'b1;
        nmi_seen = 0;
        flag_hi  = 0;
        for (int i = 0; i < FAST_SPAN + 100; i++) begin
            @(negedge vco_clk);
            if (nmi_req)   nmi_seen++;
            if (miss_flag) flag_hi++;
        end
        stat_clr = 1'b0;
        check("R6 set wins over held clear", flag_hi, 1);
        check("R7 nmi with held clear", nmi_seen, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule